// File: doc/BRIEF.md
# Two-Master Peripheral Bus Arbiter and Decoder

This block is the central controller of an on-chip peripheral bus. Two masters can start transfers on it: a processor port (master 0) and a display-refresh engine (master 1). When the bus is free, the block picks one requesting master using a rotating priority. It keeps that master granted until the transfer completes. While the grant lasts, the winner's direction, address and write data drive a single shared set of bus strobes.

The granted master's byte address is decoded into one device select per peripheral. Each peripheral owns a 1 MB window, chosen by byte-address bits 23:20. Bits 31:24 must be zero. The selected peripheral's acknowledge and read data are routed back to the granted master only. An address that hits no window is closed with an error acknowledge after a fixed count of cycles, so the bus never hangs.

Masters present word addresses, which are byte-address bits 31:2. A master holds its request and transfer fields until it sees its acknowledge. Register-style peripherals take only the two word-index bits. A memory-style peripheral takes a 20-bit word offset.

Top module: `busctl_top`

## Requirements
- R1: During reset, and in any cycle with no granted transfer, bus_rd, bus_wr, bus_sel, bus_reg_idx, bus_mem_addr and bus_wdata are all zero. In the same cycles both masters see ack, err and rdata at zero.
- R2: A request seen in an idle cycle is granted at the next clock edge. From then on, bus_rd is high when the granted master's we is 0, and bus_wr is high when its we is 1. bus_wdata carries that master's write data. Every issued transfer eventually completes.
- R3: While granted, bus_sel has at most one bit set. Bit k is set exactly when word-address bits 29:22 (byte bits 31:24) are zero and word-address bits 21:18 (byte bits 23:20) equal k, with k below NDEV.
- R4: The selected device's slv_ack is passed, in the same cycle, as ack to the granted master only. rdata for that master equals the device's slv_rdata word in its ack cycle and is zero otherwise. The other master sees ack low and rdata zero.
- R5: Once granted, a master keeps the bus until its acknowledge. Strobes, select and address outputs stay unchanged across the cycles in between.
- R6: If both masters request in the same idle cycle, the one not served most recently wins. After reset the processor port (master 0) counts as the winner.
- R7: If a granted address selects no device, ack and err rise together to the granted master in the 16th granted cycle. rdata is zero, and neither ack nor err rises earlier.
- R8: While granted, bus_reg_idx equals word-address bits 1:0 (byte bits 3:2), and bus_mem_addr equals word-address bits 19:0.
- R9: The cycle after any acknowledge is idle: no strobe and no select. A new grant can start at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| m0_req | input | 1 | Processor port request |
| m0_we | input | 1 | Processor port direction, 1 = write |
| m0_addr | input | 30 | Processor port word address (byte bits 31:2) |
| m0_wdata | input | 32 | Processor port write data |
| m0_ack | output | 1 | Processor port transfer complete |
| m0_err | output | 1 | Processor port unmapped-address error |
| m0_rdata | output | 32 | Processor port read data |
| m1_req | input | 1 | Display engine request |
| m1_we | input | 1 | Display engine direction, 1 = write |
| m1_addr | input | 30 | Display engine word address |
| m1_wdata | input | 32 | Display engine write data |
| m1_ack | output | 1 | Display engine transfer complete |
| m1_err | output | 1 | Display engine unmapped-address error |
| m1_rdata | output | 32 | Display engine read data |
| bus_rd | output | 1 | Shared read strobe |
| bus_wr | output | 1 | Shared write strobe |
| bus_sel | output | NDEV | One select per peripheral |
| bus_reg_idx | output | 2 | Word index for register peripherals |
| bus_mem_addr | output | 20 | Word offset for the memory peripheral |
| bus_wdata | output | 32 | Shared write data |
| slv_ack | input | NDEV | Per-peripheral acknowledge |
| slv_rdata | input | NDEV*32 | Per-peripheral read data, device k at bits k*32 upward |

## Verification
The masters are driven in three patterns:
- The processor port alone, which isolates decoding and response steering from arbitration.
- Both masters requesting back to back with no gaps, which exposes whether priority really alternates and whether the non-granted master stays quiet.
- The display engine alone after the processor finishes, which catches a rotation pointer that sticks.

Each pattern mixes zero-wait and slow peripherals with addresses that are out of range in the device field or in the upper bits. This separates the immediate acknowledge path from wait states and from the timeout path. Driving junk addresses on an idle master shows that the multiplexers ignore it.

// File: rtl/busctl_pkg.sv
package busctl_pkg;
    // Master identities; the order also fixes the reset-time rotation state
    typedef enum logic {
        MST_CPU  = 1'b0,
        MST_DISP = 1'b1
    } mst_e;

    // Fields of the 30-bit word address (byte address bits 31:2)
    localparam int DEV_LSB = 18;   // byte bits 23:20 select the device window
    localparam int DEV_W   = 4;
    localparam int HI_LSB  = 22;   // byte bits 31:24 must be zero
    localparam int REG_W   = 2;    // byte bits 3:2
    localparam int MEM_W   = 20;   // word offset for the memory target
endpackage

// File: rtl/busctl_arb.sv
module busctl_arb
    import busctl_pkg::*;
(
    input  logic cpu_req,
    input  logic disp_req,
    input  mst_e last_served,
    output logic any_req,
    output mst_e winner
);
    always_comb begin
        any_req = cpu_req | disp_req;
        if (cpu_req && disp_req) begin
            // the master served last drops to lowest priority
            winner = (last_served == MST_CPU) ? MST_DISP : MST_CPU;
        end else if (disp_req) begin
            winner = MST_DISP;
        end else begin
            winner = MST_CPU;
        end
    end
endmodule

// File: rtl/busctl_dec.sv
module busctl_dec
    import busctl_pkg::*;
#(
    parameter int NDEV = 6,
    parameter int AW   = 30
) (
    input  logic [AW-1:0]   addr,
    input  logic            valid,
    output logic [NDEV-1:0] sel
);
    logic in_space;
    assign in_space = valid && (addr[AW-1:HI_LSB] == '0);

    for (genvar k = 0; k < NDEV; k++) begin : g_win
        assign sel[k] = in_space && (addr[DEV_LSB +: DEV_W] == DEV_W'(k));
    end
endmodule

// File: rtl/busctl_rsp.sv
module busctl_rsp
    import busctl_pkg::*;
#(
    parameter int NDEV = 6,
    parameter int DW   = 32
) (
    input  logic [NDEV-1:0]    sel,
    input  logic [NDEV-1:0]    slv_ack,
    input  logic [NDEV*DW-1:0] slv_rdata,
    input  logic               tmo_done,
    input  mst_e               owner,
    output logic               hit,
    output logic               done,
    output logic               cpu_ack,
    output logic               cpu_err,
    output logic [DW-1:0]      cpu_rdata,
    output logic               disp_ack,
    output logic               disp_err,
    output logic [DW-1:0]      disp_rdata
);
    logic [DW-1:0] term [NDEV];
    logic [DW-1:0] rsel;
    logic          rvalid;

    for (genvar k = 0; k < NDEV; k++) begin : g_term
        assign term[k] = sel[k] ? slv_rdata[k*DW +: DW] : '0;
    end

    always_comb begin
        rsel = '0;
        for (int k = 0; k < NDEV; k++) begin
            rsel = rsel | term[k];
        end
    end

    always_comb begin
        hit        = |sel;
        done       = hit ? |(sel & slv_ack) : tmo_done;
        rvalid     = done && hit;
        cpu_ack    = done && (owner == MST_CPU);
        disp_ack   = done && (owner == MST_DISP);
        cpu_err    = tmo_done && (owner == MST_CPU);
        disp_err   = tmo_done && (owner == MST_DISP);
        cpu_rdata  = (rvalid && owner == MST_CPU)  ? rsel : '0;
        disp_rdata = (rvalid && owner == MST_DISP) ? rsel : '0;
    end
endmodule

// File: rtl/busctl_top.sv
module busctl_top
    import busctl_pkg::*;
#(
    parameter int NDEV = 6,
    parameter int DW   = 32,
    parameter int AW   = 30,
    parameter int TMO  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               m0_req,
    input  logic               m0_we,
    input  logic [AW-1:0]      m0_addr,
    input  logic [DW-1:0]      m0_wdata,
    output logic               m0_ack,
    output logic               m0_err,
    output logic [DW-1:0]      m0_rdata,
    input  logic               m1_req,
    input  logic               m1_we,
    input  logic [AW-1:0]      m1_addr,
    input  logic [DW-1:0]      m1_wdata,
    output logic               m1_ack,
    output logic               m1_err,
    output logic [DW-1:0]      m1_rdata,
    output logic               bus_rd,
    output logic               bus_wr,
    output logic [NDEV-1:0]    bus_sel,
    output logic [REG_W-1:0]   bus_reg_idx,
    output logic [MEM_W-1:0]   bus_mem_addr,
    output logic [DW-1:0]      bus_wdata,
    input  logic [NDEV-1:0]    slv_ack,
    input  logic [NDEV*DW-1:0] slv_rdata
);
    localparam int TW = $clog2(TMO);
    localparam logic [TW-1:0] TMO_LAST = TW'(TMO - 1);

    typedef struct packed {
        logic          busy;
        mst_e          own;
        mst_e          last;
        logic [TW-1:0] tmo;
    } ctl_t;

    ctl_t st_q, st_d;

    logic          any_req_d;
    mst_e          winner_d;
    logic [AW-1:0] g_addr_d;
    logic          g_we_d;
    logic [DW-1:0] g_wdata_d;
    logic          hit_d, done_d, tmo_done_d;

    busctl_arb u_arb (
        .cpu_req     (m0_req),
        .disp_req    (m1_req),
        .last_served (st_q.last),
        .any_req     (any_req_d),
        .winner      (winner_d)
    );

    // granted master's request fields
    always_comb begin
        g_addr_d  = (st_q.own == MST_DISP) ? m1_addr  : m0_addr;
        g_we_d    = (st_q.own == MST_DISP) ? m1_we    : m0_we;
        g_wdata_d = (st_q.own == MST_DISP) ? m1_wdata : m0_wdata;
    end

    busctl_dec #(.NDEV(NDEV), .AW(AW)) u_dec (
        .addr  (g_addr_d),
        .valid (st_q.busy),
        .sel   (bus_sel)
    );

    busctl_rsp #(.NDEV(NDEV), .DW(DW)) u_rsp (
        .sel        (bus_sel),
        .slv_ack    (slv_ack),
        .slv_rdata  (slv_rdata),
        .tmo_done   (tmo_done_d),
        .owner      (st_q.own),
        .hit        (hit_d),
        .done       (done_d),
        .cpu_ack    (m0_ack),
        .cpu_err    (m0_err),
        .cpu_rdata  (m0_rdata),
        .disp_ack   (m1_ack),
        .disp_err   (m1_err),
        .disp_rdata (m1_rdata)
    );

    always_comb begin
        tmo_done_d   = st_q.busy && (bus_sel == '0) && (st_q.tmo == TMO_LAST);
        bus_rd       = st_q.busy && !g_we_d;
        bus_wr       = st_q.busy && g_we_d;
        bus_reg_idx  = st_q.busy ? g_addr_d[REG_W-1:0] : '0;
        bus_mem_addr = st_q.busy ? g_addr_d[MEM_W-1:0] : '0;
        bus_wdata    = st_q.busy ? g_wdata_d : '0;

        st_d = st_q;
        if (!st_q.busy) begin
            if (any_req_d) begin
                st_d.busy = 1'b1;
                st_d.own  = winner_d;
                st_d.tmo  = '0;
            end
        end else if (done_d) begin
            st_d.busy = 1'b0;
            st_d.last = st_q.own;
            st_d.tmo  = '0;
        end else if (!hit_d) begin
            st_d.tmo = st_q.tmo + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy <= 1'b0;
            st_q.own  <= MST_CPU;
            st_q.last <= MST_DISP;
            st_q.tmo  <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/busctl_chk.sv
module busctl_chk #(
    parameter int NDEV = 6,
    parameter int TMO  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            m0_req,
    input logic            m1_req,
    input logic            m0_ack,
    input logic            m1_ack,
    input logic            m0_err,
    input logic            m1_err,
    input logic            bus_rd,
    input logic            bus_wr,
    input logic [NDEV-1:0] bus_sel,
    input logic [1:0]      bus_reg_idx,
    input logic [19:0]     bus_mem_addr
);
    logic act;
    int   miss_cnt;
    assign act = bus_rd | bus_wr;

    // cycles spent so far on a transfer that selects no device
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            miss_cnt <= 0;
        end else if (act && bus_sel == '0) begin
            miss_cnt <= miss_cnt + 1;
        end else begin
            miss_cnt <= 0;
        end
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (bus_sel == '0) && !m0_ack && !m1_ack);
    p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sel));
    p_ack_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(m0_ack && m1_ack));
    p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_ack |-> m0_req) and (m1_ack |-> m1_req));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act && !m0_ack && !m1_ack |=> act && $stable(bus_sel) && $stable(bus_reg_idx)
            && $stable(bus_mem_addr) && $stable(bus_rd));
    p_err_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_err || m1_err) |-> (bus_sel == '0) && (m0_ack || m1_ack));
    p_tmo_early_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act && bus_sel == '0 && miss_cnt != TMO - 1 |-> !m0_ack && !m1_ack);
    p_tmo_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
        act && bus_sel == '0 && miss_cnt == TMO - 1 |-> (m0_err || m1_err));
    p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (m0_ack || m1_ack) |=> !act && (bus_sel == '0));
endmodule

bind busctl_top busctl_chk #(.NDEV(NDEV), .TMO(TMO)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .m0_req       (m0_req),
    .m1_req       (m1_req),
    .m0_ack       (m0_ack),
    .m1_ack       (m1_ack),
    .m0_err       (m0_err),
    .m1_err       (m1_err),
    .bus_rd       (bus_rd),
    .bus_wr       (bus_wr),
    .bus_sel      (bus_sel),
    .bus_reg_idx  (bus_reg_idx),
    .bus_mem_addr (bus_mem_addr)
);

// File: tb/tb_busctl_top.sv
module tb_busctl_top;
    localparam int CLK_PERIOD = 10;
    localparam int NDEV = 6;
    localparam int DW   = 32;
    localparam int AW   = 30;
    localparam int TMO  = 16;
    localparam int NTX  = 24;
    localparam int WD_LIMIT = 20000;

    logic clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic rst_n;
    logic m0_req, m0_we, m1_req, m1_we;
    logic [AW-1:0] m0_addr, m1_addr;
    logic [DW-1:0] m0_wdata, m1_wdata, m0_rdata, m1_rdata, bus_wdata;
    logic m0_ack, m0_err, m1_ack, m1_err, bus_rd, bus_wr;
    logic [NDEV-1:0] bus_sel, slv_ack;
    logic [1:0] bus_reg_idx;
    logic [19:0] bus_mem_addr;
    logic [NDEV*DW-1:0] slv_rdata;

    busctl_top #(.NDEV(NDEV), .DW(DW), .AW(AW), .TMO(TMO)) dut (
        .clk(clk), .rst_n(rst_n),
        .m0_req(m0_req), .m0_we(m0_we), .m0_addr(m0_addr), .m0_wdata(m0_wdata),
        .m0_ack(m0_ack), .m0_err(m0_err), .m0_rdata(m0_rdata),
        .m1_req(m1_req), .m1_we(m1_we), .m1_addr(m1_addr), .m1_wdata(m1_wdata),
        .m1_ack(m1_ack), .m1_err(m1_err), .m1_rdata(m1_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_reg_idx(bus_reg_idx), .bus_mem_addr(bus_mem_addr), .bus_wdata(bus_wdata),
        .slv_ack(slv_ack), .slv_rdata(slv_rdata)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] mkaddr(int hi, int dev, int mid, int rg);
        return {8'(hi), 4'(dev), 16'(mid), 2'(rg)};
    endfunction

    // transaction lists per master
    logic [AW-1:0] t_addr [2][NTX];
    logic          t_we   [2][NTX];
    logic [DW-1:0] t_wd   [2][NTX];
    int            t_gap  [2][NTX];
    int            idx [2];
    int            gcnt [2];

    // reference model state
    logic busy_m, first_m, contend_m, gap_m;
    int   own_m, last_m, tmo_m;
    int   scnt [NDEV];

    logic          rq [2];
    logic          wev [2];
    logic [AW-1:0] av [2];
    logic [DW-1:0] wv [2];
    logic [AW-1:0] ga;
    logic          gwe, hit_e, tdone, done_e;
    logic [DW-1:0] gwd, rsel;
    logic [NDEV-1:0] sel_e, sa;
    int            devf, cyc, tail;
    string         stag, atag;

    initial begin
        for (int k = 0; k < NTX; k++) begin
            t_addr[0][k] = mkaddr((k % 11 == 5) ? 1 : 0, k % 8, k * 37 + 3, k % 4);
            t_we[0][k]   = (k % 3 == 0);
            t_wd[0][k]   = 32'h1000_0000 + 32'(k) * 32'h0101_0101;
            t_gap[0][k]  = (k < 8) ? 0 : ((k % 4 == 0) ? 2 : 0);
            t_addr[1][k] = mkaddr((k % 9 == 4) ? 8'h80 : 0, (k * 3 + 1) % 8, k * 91 + 7, (k + 1) % 4);
            t_we[1][k]   = (k % 2 == 1);
            t_wd[1][k]   = 32'h7700_0000 + 32'(k) * 32'h0003_0011;
            t_gap[1][k]  = (k == 0) ? 60 : ((k % 5 == 0) ? 3 : 0);
        end
        for (int m = 0; m < 2; m++) begin
            idx[m] = 0; gcnt[m] = 0;
        end
        for (int d = 0; d < NDEV; d++) scnt[d] = 0;
        busy_m = 1'b0; first_m = 1'b0; contend_m = 1'b0; gap_m = 1'b0;
        own_m = 0; last_m = 1; tmo_m = 0; cyc = 0; tail = 0;

        rst_n = 1'b0;
        m0_req = 1'b0; m0_we = 1'b1; m0_addr = '1; m0_wdata = '1;
        m1_req = 1'b1; m1_we = 1'b0; m1_addr = '1; m1_wdata = '1;
        slv_ack = '1; slv_rdata = '1;
        // R1: everything quiet while reset is held, even with inputs active
        repeat (3) begin
            @(negedge clk);
            #1;
            chk("R1", "reset bus_rd", 64'(bus_rd), 0);
            chk("R1", "reset bus_wr", 64'(bus_wr), 0);
            chk("R1", "reset bus_sel", 64'(bus_sel), 0);
            chk("R1", "reset m0_ack", 64'(m0_ack), 0);
            chk("R1", "reset m1_ack", 64'(m1_ack), 0);
            chk("R1", "reset m1_rdata", 64'(m1_rdata), 0);
            chk("R1", "reset bus_wdata", 64'(bus_wdata), 0);
        end
        @(negedge clk);
        m1_req = 1'b0; slv_ack = '0;
        rst_n = 1'b1;

        while (tail < 6 && cyc < WD_LIMIT) begin
            @(negedge clk);
            // masters drive their current transfer or idle junk
            for (int m = 0; m < 2; m++) begin
                rq[m] = (idx[m] < NTX) ? (gcnt[m] >= t_gap[m][idx[m]]) : 1'b0;
                if (rq[m]) begin
                    av[m] = t_addr[m][idx[m]]; wev[m] = t_we[m][idx[m]]; wv[m] = t_wd[m][idx[m]];
                end else begin
                    av[m] = 30'h2AAA_AAAA ^ 30'(cyc); wev[m] = cyc[0]; wv[m] = 32'hDEAD_0000 | 32'(cyc);
                end
            end
            m0_req = rq[0]; m0_we = wev[0]; m0_addr = av[0]; m0_wdata = wv[0];
            m1_req = rq[1]; m1_we = wev[1]; m1_addr = av[1]; m1_wdata = wv[1];

            ga = av[own_m]; gwe = wev[own_m]; gwd = wv[own_m];
            devf  = int'(ga[21:18]);
            hit_e = busy_m && (ga[29:22] == '0) && (devf < NDEV);
            sel_e = hit_e ? (NDEV'(1) << devf) : '0;
            for (int d = 0; d < NDEV; d++) begin
                sa[d] = sel_e[d] && (scnt[d] == d % 3);
                slv_rdata[d*DW +: DW] = 32'h5A00_0000 + (32'(d) << 16) + 32'(cyc);
            end
            slv_ack = sa;
            tdone  = busy_m && !hit_e && (tmo_m == TMO - 1);
            done_e = busy_m && (hit_e ? sa[devf] : tdone);
            rsel   = hit_e ? slv_rdata[devf*DW +: DW] : '0;
            #1;

            stag = !busy_m ? (gap_m ? "R9" : "R1") : (first_m ? (contend_m ? "R6" : "R2") : "R5");
            atag = !busy_m ? "R1" : (hit_e ? "R4" : "R7");
            chk(stag, "bus_rd", 64'(bus_rd), 64'(busy_m && !gwe));
            chk(stag, "bus_wr", 64'(bus_wr), 64'(busy_m && gwe));
            chk(busy_m ? "R3" : stag, "bus_sel", 64'(bus_sel), 64'(sel_e));
            chk(busy_m ? "R8" : stag, "bus_reg_idx", 64'(bus_reg_idx), busy_m ? 64'(ga[1:0]) : 0);
            chk(busy_m ? "R8" : stag, "bus_mem_addr", 64'(bus_mem_addr), busy_m ? 64'(ga[19:0]) : 0);
            chk(busy_m ? "R2" : stag, "bus_wdata", 64'(bus_wdata), busy_m ? 64'(gwd) : 0);
            chk(atag, "m0_ack", 64'(m0_ack), 64'(done_e && own_m == 0));
            chk(atag, "m1_ack", 64'(m1_ack), 64'(done_e && own_m == 1));
            chk("R7", "m0_err", 64'(m0_err), 64'(tdone && own_m == 0));
            chk("R7", "m1_err", 64'(m1_err), 64'(tdone && own_m == 1));
            chk("R4", "m0_rdata", 64'(m0_rdata), (done_e && hit_e && own_m == 0) ? 64'(rsel) : 0);
            chk("R4", "m1_rdata", 64'(m1_rdata), (done_e && hit_e && own_m == 1) ? 64'(rsel) : 0);

            // advance masters, slaves and the reference model
            for (int m = 0; m < 2; m++) begin
                if (done_e && own_m == m) begin
                    idx[m]++; gcnt[m] = 0;
                end else if (!rq[m]) begin
                    gcnt[m]++;
                end
            end
            for (int d = 0; d < NDEV; d++) scnt[d] = (sel_e[d] && !sa[d]) ? scnt[d] + 1 : 0;
            if (!busy_m) begin
                gap_m = 1'b0;
                if (rq[0] || rq[1]) begin
                    busy_m = 1'b1; first_m = 1'b1; tmo_m = 0;
                    contend_m = rq[0] && rq[1];
                    own_m = contend_m ? (1 - last_m) : (rq[0] ? 0 : 1);
                end
            end else if (done_e) begin
                busy_m = 1'b0; last_m = own_m; gap_m = 1'b1; first_m = 1'b0;
            end else begin
                first_m = 1'b0;
                if (!hit_e) tmo_m++;
            end
            cyc++;
            if (idx[0] == NTX && idx[1] == NTX) tail++;
        end

        if (cyc >= WD_LIMIT) begin
            checks++; fails++;
            $display("FAIL R2 watchdog expired actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
        end
        chk("R2", "m0 completed", 64'(idx[0]), 64'(NTX));
        chk("R2", "m1 completed", 64'(idx[1]), 64'(NTX));
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule